// File: doc/BRIEF.md
# Core Run-State Controller

This block keeps the operating state of a serial controller core. There are three legal states: RESET, RUN and PAUSE. Software asks for a new state through a write port and polls a 3-bit status word that holds a valid flag and the current state code. A state change takes time to settle. While it settles the valid flag is low, and requests that arrive during that window are dropped. A separate software-reset strobe returns the core to RESET at once. The transfer datapath gets an enable that is high only while the core is in RUN and the state is valid.

Leaving PAUSE for RESET needs two RESET requests with no other request between them. The first one only arms the block. When the datapath signals the end of a transfer, successful or failed, while the core is in RUN, the core falls back to RESET on its own. It goes through the same settling window as a software request.

Top module: `run_state_ctl`

## Requirements
- R1: After `rstN` is released, `statusRd` reads 3'b110 (valid, RESET) and `runEnable` is low.
- R2: `statusRd[2]` is the valid flag and `statusRd[1:0]` is the state. The codes are RUN = 2'b01, RESET = 2'b10 and PAUSE = 2'b11.
- R3: A state request is accepted when valid is high and the code is legal. On acceptance the state field shows the new code one cycle after the write edge, and valid stays low for exactly `SETTLE_CYCLES` (default 3) cycles before it returns high.
- R4: A state request or a transfer-end pulse that arrives while valid is low has no effect.
- R5: The request field is `REQ_W` bits wide (default 3). Codes 0 and any value above 3 are ignored and leave the status unchanged.
- R6: In PAUSE, a single RESET request leaves the status at PAUSE and valid. A second RESET request in a row moves the core to RESET through the settling window.
- R7: Any other request made while armed, illegal codes included, cancels the arming. Two fresh RESET requests are then needed.
- R8: A software-reset write with data 1 forces the status to 3'b110 on the next cycle, even in the middle of settling. A write with data 0 has no effect.
- R9: `xferEnd` while the status is valid RUN moves the core to RESET through the settling window. In any other state, or while not valid, it is ignored.
- R10: `runEnable` is high exactly when the status is 3'b101.
- R11: Priority, highest first: software reset, then a state request, then `xferEnd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stateWrEn | input | 1 | State request strobe |
| stateWrData | input | REQ_W | Requested state code |
| swRstWrEn | input | 1 | Software-reset register write strobe |
| swRstWrData | input | 1 | Software-reset write data; 1 forces RESET |
| xferEnd | input | 1 | Datapath pulse at the end of a transfer, successful or failed |
| statusRd | output | 3 | {valid, state} for polling |
| runEnable | output | 1 | Datapath may run |

## Verification
Every response is registered, so a request sampled at edge N shows on `statusRd` after edge N, with valid low and the new code. Valid goes high again after edge N+3. A software reset is visible after edge N. The bench drives inputs on falling edges and reads outputs on the following falling edge, half a cycle after they change. A behavioural model counts the remaining settling cycles and the arming for every input pattern, and it is compared with the outputs on every falling edge. Directed checks at hand-computed cycles confirm the one-cycle and four-cycle points.

// File: rtl/run_state_pkg.sv
package run_state_pkg;

  typedef enum logic [1:0] {
    RS_RUN   = 2'b01,
    RS_RESET = 2'b10,
    RS_PAUSE = 2'b11
  } runState_e;

  // Strobes from the request decoder to the state registers.
  typedef struct packed {
    logic      forceReset;
    logic      loadState;
    logic      armPause;
    logic      clearArm;
    runState_e target;
  } ctlStrobe_t;

endpackage

// File: rtl/run_state_decode.sv
module run_state_decode
  import run_state_pkg::*;
#(
  parameter int REQ_W = 3
) (
  input  logic             swRstWrEn,
  input  logic             swRstWrData,
  input  logic             stateWrEn,
  input  logic [REQ_W-1:0] stateWrData,
  input  logic             xferEnd,
  input  runState_e        curState,
  input  logic             curValid,
  input  logic             armed,
  output ctlStrobe_t       strobe
);

  localparam logic [REQ_W-1:0] MAX_CODE = REQ_W'(3);

  logic      swHit;
  logic      legalReq;
  runState_e reqState;
  logic      pauseToReset;

  assign swHit        = swRstWrEn & swRstWrData;
  assign legalReq     = (stateWrData != '0) && (stateWrData <= MAX_CODE);
  assign reqState     = runState_e'(stateWrData[1:0]);
  assign pauseToReset = legalReq && (curState == RS_PAUSE) && (reqState == RS_RESET);

  always_comb begin
    strobe        = '0;
    strobe.target = RS_RESET;
    if (swHit) begin
      strobe.forceReset = 1'b1;
      strobe.clearArm   = 1'b1;
    end else if (curValid) begin
      if (stateWrEn) begin
        if (pauseToReset && !armed) begin
          strobe.armPause = 1'b1;
        end else begin
          strobe.clearArm = 1'b1;
          if (legalReq) begin
            strobe.loadState = 1'b1;
            strobe.target    = reqState;
          end
        end
      end else if (xferEnd && curState == RS_RUN) begin
        strobe.loadState = 1'b1;
        strobe.clearArm  = 1'b1;
        strobe.target    = RS_RESET;
      end
    end
  end

endmodule

// File: rtl/run_state_regs.sv
module run_state_regs
  import run_state_pkg::*;
#(
  parameter int SETTLE_CYCLES = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t strobe,
  output runState_e  curState,
  output logic       curValid,
  output logic       armed
);

  localparam int CNT_W = (SETTLE_CYCLES < 2) ? 1 : $clog2(SETTLE_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYCLES - 1);

  logic [CNT_W-1:0] settleCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curState  <= RS_RESET;
      curValid  <= 1'b1;
      settleCnt <= '0;
      armed     <= 1'b0;
    end else if (strobe.forceReset) begin
      curState  <= RS_RESET;
      curValid  <= 1'b1;
      settleCnt <= '0;
      armed     <= 1'b0;
    end else begin
      if (strobe.clearArm) begin
        armed <= 1'b0;
      end else if (strobe.armPause) begin
        armed <= 1'b1;
      end
      if (strobe.loadState) begin
        curState  <= strobe.target;
        curValid  <= 1'b0;
        settleCnt <= CNT_LOAD;
      end else if (!curValid) begin
        if (settleCnt == '0) begin
          curValid <= 1'b1;
        end else begin
          settleCnt <= settleCnt - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/run_state_ctl.sv
module run_state_ctl
  import run_state_pkg::*;
#(
  parameter int SETTLE_CYCLES = 3,
  parameter int REQ_W         = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stateWrEn,
  input  logic [REQ_W-1:0] stateWrData,
  input  logic             swRstWrEn,
  input  logic             swRstWrData,
  input  logic             xferEnd,
  output logic [2:0]       statusRd,
  output logic             runEnable
);

  ctlStrobe_t strobe;
  runState_e  curState;
  logic       curValid;
  logic       armed;

  run_state_decode #(.REQ_W(REQ_W)) u_decode (
    .swRstWrEn   (swRstWrEn),
    .swRstWrData (swRstWrData),
    .stateWrEn   (stateWrEn),
    .stateWrData (stateWrData),
    .xferEnd     (xferEnd),
    .curState    (curState),
    .curValid    (curValid),
    .armed       (armed),
    .strobe      (strobe)
  );

  run_state_regs #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .curState (curState),
    .curValid (curValid),
    .armed    (armed)
  );

  assign statusRd  = {curValid, curState};
  assign runEnable = curValid && (curState == RS_RUN);

endmodule

// File: rtl/run_state_chk.sv
module run_state_chk #(
  parameter int REQ_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             stateWrEn,
  input logic [REQ_W-1:0] stateWrData,
  input logic             swRstWrEn,
  input logic             swRstWrData,
  input logic             xferEnd,
  input logic [2:0]       statusRd,
  input logic             runEnable
);

  logic swHit;
  logic legalReq;
  assign swHit    = swRstWrEn && swRstWrData;
  assign legalReq = (stateWrData != '0) && (stateWrData <= REQ_W'(3));

  assert_sw_reset_R8: assert property (@(posedge clk) disable iff (!rstN)
    swHit |=> statusRd == 3'b110);

  assert_frozen_while_settling_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!statusRd[2] && !swHit) |=> $stable(statusRd[1:0]));

  assert_accept_drops_valid_R3: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd[2] && !swHit && stateWrEn && legalReq &&
     !(statusRd[1:0] == 2'b11 && stateWrData == REQ_W'(2)))
    |=> statusRd == {1'b0, $past(stateWrData[1:0])});

  assert_illegal_ignored_R5: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd[2] && !swHit && stateWrEn && !legalReq) |=> $stable(statusRd));

  assert_pause_exit_R6: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd == 3'b111 && stateWrEn && stateWrData == REQ_W'(2) && !swHit)
    |=> (statusRd == 3'b111 || statusRd == 3'b010));

  assert_xfer_end_R9: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd == 3'b101 && xferEnd && !stateWrEn && !swHit) |=> statusRd == 3'b010);

  assert_run_enable_R10: assert property (@(posedge clk) disable iff (!rstN)
    runEnable == (statusRd == 3'b101));

endmodule

bind run_state_ctl run_state_chk #(.REQ_W(REQ_W)) u_chk (.*);

// File: tb/run_state_ctl_tb.sv
`timescale 1ns/1ps
module run_state_ctl_tb;

  localparam int REQ_W = 3;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             stateWrEn = 1'b0;
  logic [REQ_W-1:0] stateWrData = '0;
  logic             swRstWrEn = 1'b0;
  logic             swRstWrData = 1'b0;
  logic             xferEnd = 1'b0;
  logic [2:0]       statusRd;
  logic             runEnable;

  int    testsRun = 0;
  int    testsFailed = 0;
  int    cycles = 0;
  string curReq = "R1";
  bit    modelLive = 0;

  // behavioural reference
  int mState = 2;
  int mValid = 1;
  int mLeft  = 0;
  int mArmed = 0;

  always #2.5 clk = ~clk;

  run_state_ctl #(.SETTLE_CYCLES(3), .REQ_W(REQ_W)) u_dut (
    .clk(clk), .rstN(rstN), .stateWrEn(stateWrEn), .stateWrData(stateWrData),
    .swRstWrEn(swRstWrEn), .swRstWrData(swRstWrData), .xferEnd(xferEnd),
    .statusRd(statusRd), .runEnable(runEnable)
  );

  always @(posedge clk) begin
    int d;
    bit legal;
    d = int'(stateWrData);
    legal = (d >= 1 && d <= 3);
    if (!rstN) begin
      mState = 2; mValid = 1; mLeft = 0; mArmed = 0;
    end else if (swRstWrEn && swRstWrData) begin
      mState = 2; mValid = 1; mLeft = 0; mArmed = 0;
    end else if (mValid == 1) begin
      if (stateWrEn) begin
        if (legal && mState == 3 && d == 2 && mArmed == 0) begin
          mArmed = 1;
        end else begin
          mArmed = 0;
          if (legal) begin mState = d; mValid = 0; mLeft = 3; end
        end
      end else if (xferEnd && mState == 1) begin
        mState = 2; mValid = 0; mLeft = 3; mArmed = 0;
      end
    end else begin
      mLeft = mLeft - 1;
      if (mLeft == 0) mValid = 1;
    end
  end

  always @(negedge clk) begin
    if (modelLive) begin
      logic [2:0] expS;
      expS = {mValid[0], mState[1:0]};
      testsRun++;
      if (statusRd !== expS) begin
        testsFailed++;
        $display("FAIL %s model statusRd actual=%b expected=%b", curReq, statusRd, expS);
      end
      testsRun++;
      if (runEnable !== (mValid == 1 && mState == 1)) begin
        testsFailed++;
        $display("FAIL R10 (%s) model runEnable actual=%b expected=%b", curReq, runEnable,
                 (mValid == 1 && mState == 1));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 100000) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired actual=%0d cycles expected=<100000", cycles);
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [2:0] exp);
    testsRun++;
    if (statusRd !== exp) begin
      testsFailed++;
      $display("FAIL %s statusRd actual=%b expected=%b", req, statusRd, exp);
    end
  endtask

  task automatic chkRun(input string req, input logic exp);
    testsRun++;
    if (runEnable !== exp) begin
      testsFailed++;
      $display("FAIL %s runEnable actual=%b expected=%b", req, runEnable, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrState(input int code);
    stateWrEn = 1'b1; stateWrData = REQ_W'(code);
    @(negedge clk);
    stateWrEn = 1'b0; stateWrData = '0;
  endtask

  task automatic swReset(input logic val);
    swRstWrEn = 1'b1; swRstWrData = val;
    @(negedge clk);
    swRstWrEn = 1'b0; swRstWrData = 1'b0;
  endtask

  task automatic pulseEnd();
    xferEnd = 1'b1;
    @(negedge clk);
    xferEnd = 1'b0;
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    modelLive = 1;
    idle(1);
    curReq = "R1";
    chk("R1", 3'b110); chkRun("R1", 1'b0);

    // R3 / R2: RESET -> RUN, valid low for 3 cycles
    curReq = "R3";
    wrState(1);
    chk("R3", 3'b001); chkRun("R10", 1'b0);
    idle(2); chk("R3", 3'b001);
    idle(1); chk("R2", 3'b101); chkRun("R10", 1'b1);

    // R4: request while settling dropped
    curReq = "R4";
    wrState(3);
    chk("R3", 3'b011);
    wrState(1);
    chk("R4", 3'b011);
    pulseEnd();
    idle(1); chk("R4", 3'b111);

    // R6: PAUSE needs two RESET requests
    curReq = "R6";
    wrState(2);
    chk("R6", 3'b111);
    idle(2); chk("R6", 3'b111);
    wrState(2);
    chk("R6", 3'b010);
    idle(3); chk("R6", 3'b110);

    // R7: arming cancelled by another request
    curReq = "R7";
    wrState(3); idle(3); chk("R7", 3'b111);
    wrState(2); chk("R7", 3'b111);
    wrState(0); chk("R5", 3'b111);
    wrState(2); chk("R7", 3'b111);
    wrState(2); chk("R7", 3'b010);
    idle(3);

    // R5: illegal codes
    curReq = "R5";
    wrState(4); chk("R5", 3'b110);
    wrState(7); chk("R5", 3'b110);
    wrState(0); chk("R5", 3'b110);

    // R8: software reset
    curReq = "R8";
    swReset(1'b0); chk("R8", 3'b110);
    wrState(1); chk("R8", 3'b001);
    swReset(1'b1); chk("R8", 3'b110);
    wrState(3); idle(3); chk("R8", 3'b111);
    swReset(1'b1); chk("R8", 3'b110);

    // R9: transfer end
    curReq = "R9";
    pulseEnd(); chk("R9", 3'b110);
    wrState(1); idle(3); chk("R9", 3'b101);
    pulseEnd(); chk("R9", 3'b010); chkRun("R9", 1'b0);
    idle(3); chk("R9", 3'b110);

    // R11: priority
    curReq = "R11";
    stateWrEn = 1'b1; stateWrData = REQ_W'(1); swRstWrEn = 1'b1; swRstWrData = 1'b1;
    @(negedge clk);
    stateWrEn = 1'b0; swRstWrEn = 1'b0; swRstWrData = 1'b0;
    chk("R11", 3'b110);
    wrState(1); idle(3);
    stateWrEn = 1'b1; stateWrData = REQ_W'(3); xferEnd = 1'b1;
    @(negedge clk);
    stateWrEn = 1'b0; xferEnd = 1'b0;
    chk("R11", 3'b011);
    idle(3);

    // mixed traffic against the model
    curReq = "R3-mix";
    for (int i = 0; i < 4000; i++) begin
      stateWrEn   = ($urandom_range(0, 2) == 0);
      stateWrData = REQ_W'($urandom_range(0, 7));
      swRstWrEn   = ($urandom_range(0, 40) == 0);
      swRstWrData = $urandom_range(0, 1) == 1;
      xferEnd     = ($urandom_range(0, 4) == 0);
      @(negedge clk);
    end
    stateWrEn = 1'b0; swRstWrEn = 1'b0; xferEnd = 1'b0;
    idle(5);

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule